// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides the local-oscillator clock by a 15-bit ratio N with a two-modulus scheme. A prescaler model runs on the oscillator clock and divides by 16 or by 17. A main counter counts prescaler periods. A swallow counter holds the prescaler at 17 for the first few of those periods. One output period is therefore 16·M + A input clocks, where M is the upper eleven bits of the ratio and A is the lower four bits. Every part is ordinary synchronous logic clocked by the oscillator clock.

The feedback pulse is one clock wide and goes to a phase comparator. The block also drives a half-rate square wave for a test port. A new ratio is loaded with a single-cycle strobe. The block holds it until the current output period ends, so an output period is never shortened. A ratio below the smallest usable value of 240 is raised to 240. This keeps M at least as large as A, which the swallow scheme needs.

Top module: `lo_swallow_divider`

## Requirements
- R1: With ratio word N applied, `fpd_o` pulses once every N clocks, where N = 16·M + A, M = `ratio_i[14:4]` and A = `ratio_i[3:0]`.
- R2: Within each output period, the prescaler divides by 17 for the first A prescaler periods and by 16 for the rest. The period is therefore exact both for A = 0 and for A = 15.
- R3: `fpd_o` is high for exactly one clock per output period.
- R4: A ratio word below 240 is treated as 240.
- R5: `fpd_half_o` toggles in the clock where `fpd_o` is high and at no other time. It is therefore high for N clocks and low for N clocks.
- R6: A ratio loaded during an output period does not change that period's length. It applies from the next full period.
- R7: The largest ratio, 32767 (M = 2047, A = 15), gives an output period of 32767 clocks.
- R8: During reset, `fpd_o` and `fpd_half_o` are low. After reset, the divider runs at ratio 240 until a ratio is loaded.
- R9: If several loads arrive within one output period, the last one is used for the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local-oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 15 | Division ratio word, M in the upper 11 bits and A in the lower 4 |
| load_i | input | 1 | Single-cycle strobe that captures `ratio_i` |
| fpd_o | output | 1 | Divided pulse, one clock wide, once per N clocks |
| fpd_half_o | output | 1 | Half-rate square wave that toggles on each `fpd_o` pulse |

## Verification
The hardest case to reach from the ports is a load that arrives in the middle of an output period. The in-progress period must keep its old length, and the new ratio must govern the following one. The stimulus first syncs to a pulse, then counts a fixed number of clocks before it strobes a much smaller ratio. It keeps counting to the next pulse, so the in-progress interval is measured across the load. A second case sends two loads in one period to show that the later one wins. The swallow edge cases come from ratios with A at 0 and at 15, including the minimum and maximum ratio.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int unsigned DEF_M_W   = 11;
  localparam int unsigned DEF_A_W   = 4;
  localparam int unsigned DEF_N_MIN = 240;

  typedef enum logic {
    PRE_BASE = 1'b0,
    PRE_PLUS = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/swdiv_ratio_stage.sv
module swdiv_ratio_stage #(
  parameter int unsigned M_W   = swdiv_pkg::DEF_M_W,
  parameter int unsigned A_W   = swdiv_pkg::DEF_A_W,
  parameter int unsigned N_MIN = swdiv_pkg::DEF_N_MIN,
  localparam int unsigned N_W  = M_W + A_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] ratio_i,
  input  logic           load_i,
  input  logic           cyc_end_i,
  output logic [M_W-1:0] next_m_o,
  output logic [A_W-1:0] next_a_o
);
  localparam logic [N_W-1:0] FLOOR = N_W'(N_MIN);

  logic [N_W-1:0] req_clamped;
  logic [N_W-1:0] pend_q, act_q, next_ratio;
  logic           pend_vld_q;

  assign req_clamped = (ratio_i < FLOOR) ? FLOOR : ratio_i;

  always_comb begin
    if (load_i)          next_ratio = req_clamped;
    else if (pend_vld_q) next_ratio = pend_q;
    else                 next_ratio = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= FLOOR;
      pend_vld_q <= 1'b0;
      act_q      <= FLOOR;
    end else if (cyc_end_i) begin
      act_q      <= next_ratio;
      pend_vld_q <= 1'b0;
    end else if (load_i) begin
      pend_q     <= req_clamped;
      pend_vld_q <= 1'b1;
    end
  end

  assign next_m_o = next_ratio[N_W-1:A_W];
  assign next_a_o = next_ratio[A_W-1:0];

  assert_active_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q >= FLOOR);

  assert_hold_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end_i |=> $stable(act_q));
endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned A_W  = swdiv_pkg::DEF_A_W,
  localparam int unsigned PRE_W = A_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  swdiv_pkg::pre_mode_e mode_i,
  output logic                pre_end_o
);
  localparam logic [PRE_W-1:0] LAST_BASE = PRE_W'((1 << A_W) - 1);
  localparam logic [PRE_W-1:0] LAST_PLUS = PRE_W'(1 << A_W);

  logic [PRE_W-1:0] cnt_q;

  assign pre_end_o = (mode_i == swdiv_pkg::PRE_PLUS) ? (cnt_q == LAST_PLUS)
                                                     : (cnt_q == LAST_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (pre_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + PRE_W'(1);
  end

  assert_pre_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_PLUS);

  assert_pre_base_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == swdiv_pkg::PRE_BASE) |-> (cnt_q <= LAST_BASE));
endmodule

// File: rtl/swdiv_cycle_ctrl.sv
module swdiv_cycle_ctrl #(
  parameter int unsigned M_W   = swdiv_pkg::DEF_M_W,
  parameter int unsigned A_W   = swdiv_pkg::DEF_A_W,
  parameter int unsigned N_MIN = swdiv_pkg::DEF_N_MIN
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pre_end_i,
  input  logic [M_W-1:0]       next_m_i,
  input  logic [A_W-1:0]       next_a_i,
  output swdiv_pkg::pre_mode_e mode_o,
  output logic                 cyc_end_o
);
  localparam logic [M_W-1:0] RST_M_LEFT = M_W'((N_MIN >> A_W) - 1);
  localparam logic [A_W-1:0] RST_A_LEFT = A_W'(N_MIN % (1 << A_W));

  logic [M_W-1:0] m_left_q;
  logic [A_W-1:0] a_left_q;

  assign cyc_end_o = pre_end_i && (m_left_q == '0);
  assign mode_o    = (a_left_q != '0) ? swdiv_pkg::PRE_PLUS : swdiv_pkg::PRE_BASE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_left_q <= RST_M_LEFT;
      a_left_q <= RST_A_LEFT;
    end else if (cyc_end_o) begin
      m_left_q <= next_m_i - M_W'(1);
      a_left_q <= next_a_i;
    end else if (pre_end_i) begin
      m_left_q <= m_left_q - M_W'(1);
      if (a_left_q != '0) a_left_q <= a_left_q - A_W'(1);
    end
  end

  // swallow count must drain before the main count runs out
  assert_swallow_fits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, a_left_q} <= ({1'b0, m_left_q} + (M_W+1)'(1)));
endmodule

// File: rtl/swdiv_out_stage.sv
module swdiv_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_end_i,
  output logic fpd_o,
  output logic fpd_half_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fpd_o      <= 1'b0;
      fpd_half_o <= 1'b0;
    end else begin
      fpd_o      <= cyc_end_i;
      fpd_half_o <= fpd_half_o ^ cyc_end_i;
    end
  end

  assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpd_o |=> !fpd_o);

  assert_half_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpd_half_o != $past(fpd_half_o)) |-> fpd_o);
endmodule

// File: rtl/lo_swallow_divider.sv
module lo_swallow_divider #(
  parameter int unsigned M_W   = swdiv_pkg::DEF_M_W,
  parameter int unsigned A_W   = swdiv_pkg::DEF_A_W,
  parameter int unsigned N_MIN = swdiv_pkg::DEF_N_MIN,
  localparam int unsigned N_W  = M_W + A_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] ratio_i,
  input  logic           load_i,
  output logic           fpd_o,
  output logic           fpd_half_o
);
  logic                 pre_end, cyc_end;
  logic [M_W-1:0]       next_m;
  logic [A_W-1:0]       next_a;
  swdiv_pkg::pre_mode_e mode;

  swdiv_ratio_stage #(.M_W(M_W), .A_W(A_W), .N_MIN(N_MIN)) u_ratio (
    .clk_i, .rst_ni, .ratio_i, .load_i,
    .cyc_end_i(cyc_end), .next_m_o(next_m), .next_a_o(next_a)
  );

  swdiv_prescaler #(.A_W(A_W)) u_pre (
    .clk_i, .rst_ni, .mode_i(mode), .pre_end_o(pre_end)
  );

  swdiv_cycle_ctrl #(.M_W(M_W), .A_W(A_W), .N_MIN(N_MIN)) u_ctrl (
    .clk_i, .rst_ni, .pre_end_i(pre_end), .next_m_i(next_m), .next_a_i(next_a),
    .mode_o(mode), .cyc_end_o(cyc_end)
  );

  swdiv_out_stage u_out (
    .clk_i, .rst_ni, .cyc_end_i(cyc_end), .fpd_o, .fpd_half_o
  );
endmodule

// File: tb/lo_swallow_divider_test.sv
`timescale 1ns/1ps
module lo_swallow_divider_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] ratio_i = '0;
  logic        load_i = 1'b0;
  logic        fpd_o, fpd_half_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;

  lo_swallow_divider uut (.clk_i, .rst_ni, .ratio_i, .load_i, .fpd_o, .fpd_half_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk_i); while (!fpd_o);
  endtask

  task automatic measure(output int n);
    wait_pulse();
    n = 0;
    do begin @(negedge clk_i); n++; end while (!fpd_o && n < 40000);
  endtask

  task automatic load_ratio(input int v);
    ratio_i = 15'(v);
    load_i  = 1'b1;
    @(negedge clk_i);
    load_i  = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk_i);
    check(fpd_o == 1'b0, "R8 fpd in reset", int'(fpd_o), 0);
    check(fpd_half_o == 1'b0, "R8 half in reset", int'(fpd_half_o), 0);
    rst_ni = 1'b1;
    measure(n);
    check(n == 240, "R8 period after reset", n, 240);
  endtask

  task automatic t_ratio(input int v, input int exp, input string req);
    int n;
    load_ratio(v);
    wait_pulse();
    measure(n);
    check(n == exp, req, n, exp);
    @(negedge clk_i);
    check(fpd_o == 1'b0, "R3 pulse width", int'(fpd_o), 0);
  endtask

  task automatic t_midcycle();
    int n;
    wait_pulse();
    n = 0;
    repeat (10) begin @(negedge clk_i); n++; end
    ratio_i = 15'd300;
    load_i  = 1'b1;
    @(negedge clk_i); n++;
    load_i  = 1'b0;
    while (!fpd_o) begin @(negedge clk_i); n++; end
    check(n == 1000, "R6 current period kept", n, 1000);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!fpd_o && n < 40000);
    check(n == 300, "R6 next period new", n, 300);
  endtask

  task automatic t_last_wins();
    int n;
    wait_pulse();
    repeat (5) @(negedge clk_i);
    load_ratio(500);
    repeat (5) @(negedge clk_i);
    load_ratio(700);
    wait_pulse();
    measure(n);
    check(n == 700, "R9 last load wins", n, 700);
  endtask

  task automatic t_half();
    int hi, lo;
    bit prev;
    prev = fpd_half_o;
    do begin
      prev = fpd_half_o;
      @(negedge clk_i);
    end while (!(fpd_half_o && !prev));
    check(fpd_o == 1'b1, "R5 toggle with pulse", int'(fpd_o), 1);
    hi = 0;
    while (fpd_half_o && hi < 40000) begin hi++; @(negedge clk_i); end
    check(fpd_o == 1'b1, "R5 fall with pulse", int'(fpd_o), 1);
    lo = 0;
    while (!fpd_half_o && lo < 40000) begin lo++; @(negedge clk_i); end
    check(hi == 300, "R5 high time", hi, 300);
    check(lo == 300, "R5 low time", lo, 300);
  endtask

  initial begin
    t_reset();
    t_ratio(241,  241,  "R1 A=1");
    t_ratio(255,  255,  "R2 M=15 A=15");
    t_ratio(256,  256,  "R2 M=16 A=0");
    t_ratio(4095, 4095, "R1 M=255 A=15");
    t_ratio(100,  240,  "R4 clamp 100");
    t_ratio(0,    240,  "R4 clamp 0");
    t_ratio(239,  240,  "R4 clamp 239");
    t_ratio(240,  240,  "R2 min ratio A=0");
    t_ratio(1000, 1000, "R1 ratio 1000");
    t_midcycle();
    t_half();
    t_last_wins();
    t_ratio(32767, 32767, "R7 max ratio");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule